// File: doc/BRIEF.md
# Addressed Serial Control Port

This block is the control-side slave of a three-wire serial link (chip enable, serial clock, data in) with an open-drain data-out line. Each transfer opens with chip enable high and an 8-bit address. Two addresses select one of two 24-bit control banks and one selects a status read-out. For a write, the data bits are staged in a shift register. The selected bank is updated only at the falling edge of chip enable, and only when the frame had exactly the right length. Frames with an unknown address or a wrong bit count are dropped.

Between transfers, the data-out line carries a status source chosen by a 3-bit code in the second bank: the unlock flag, the counter-done flag, or the level of one of two bidirectional port pins. During a read transfer, the line shifts out a status word MSB first. All pin inputs are brought into a single system clock domain through synchronizers. Bits are sampled on the rising edge of the serial clock. The bank fields drive other blocks directly.

Top module: `serial_ctl_if`

## Requirements
- R1: After reset: divisor, mode bits, counter start, reference select, port outputs, port directions (both inputs), gate, dead zone, unlock width and data-out code are all zero, and the crystal select bit is 1. The data-out line is open (`do_low_o`=0).
- R2: A transfer whose eight address bits arrive in the order 0,0,0,1,0,1,0,0, followed by exactly 24 data bits, writes bank 1. Data bit k is the k-th bit sent after the address. Field layout: divisor [15:0] (bit 0 is the LSB), SNS-style mode [16], divider select [17], counter start [18], crystal select [19], reference select [23:20].
- R3: Address order 1,0,0,1,0,1,0,0 with 24 data bits writes bank 2. Field layout: port directions [1:0], dedicated port outputs [5:2], I/O port outputs [7:6], data-out code [10:8] (bit 8 is the LSB), gate time [12:11], dead zone [14:13], unlock width [16:15], spare [23:17].
- R4: Bank outputs keep their old values while chip enable is still high after the last bit. They change only after chip enable falls.
- R5: A frame whose address matches no bank leaves both banks unchanged.
- R6: A bank frame with fewer or more than 24 data bits leaves both banks unchanged.
- R7: While chip enable is high during any non-read transfer, the data-out line is open whatever the data-out code.
- R8: With chip enable low, data-out code 1 pulls the line low exactly while `unlock_i` is 1, and code 2 pulls it low exactly while `cnt_done_i` is 1. Codes 0, 3, 4 and 7 leave it open.
- R9: Code 5 (port 0) and code 6 (port 1) pull the line low when the pin reads low and leave it open when the pin reads high. If that port is set as an output, the line is open.
- R10: Address order 0,1,0,1,0,1,0,0 starts a read. From the first serial-clock rise after the address onward, rise k shows bit (23-k) of `status_i` as captured at the eighth address rise, with 0 meaning line low. A read changes no bank.
- R11: An I/O port pin is driven low only when its direction bit is 1 and its output bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip enable pin |
| sck_i | input | 1 | Serial clock pin |
| sdi_i | input | 1 | Serial data in pin |
| io_pin_i | input | 2 | Levels read back from the two I/O port pins |
| unlock_i | input | 1 | Unlock flag from the lock detector |
| cnt_done_i | input | 1 | Measurement-complete flag from the frequency counter |
| status_i | input | 24 | Status word for read transfers |
| divisor_o | output | 16 | Divider setting |
| sns_o | output | 1 | Low-band divider mode |
| dvs_o | output | 1 | Divider input select |
| cte_o | output | 1 | Counter start |
| xtal_sel_o | output | 1 | Crystal select |
| ref_sel_o | output | 4 | Reference frequency select |
| io_dir_o | output | 2 | I/O port direction (1 = output) |
| bo_low_o | output | 4 | Dedicated port outputs (1 = pull low) |
| io_low_o | output | 2 | I/O port pull-low enables |
| gate_sel_o | output | 2 | Counter gate time select |
| dz_sel_o | output | 2 | Phase detector dead zone select |
| ul_sel_o | output | 2 | Unlock detection width select |
| do_low_o | output | 1 | Data-out pull-down enable (0 = open) |

## Verification
On every cycle, the checker enforces the following:
- The banks change only in the cycle after a chip-enable fall, and never for a wrong length or a foreign address.
- Data-out stays open during input transfers.
- The unlock source is routed faithfully.
- A port set as an output never reaches data-out.
- No I/O pin is driven without output direction.

Field placement, the MSB-first read-out order and its alignment to the serial clock, the counter-done and pin-level routing, and the hold-until-fall behaviour seen at the ports are shown only by the bench's directed and random transfers, which are compared against a reference model of both banks.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int ADDR_W  = 8;
  localparam int FRAME_W = 24;
  // address bit k = k-th bit sent
  localparam logic [ADDR_W-1:0] ADDR_BANK1 = 8'h28;
  localparam logic [ADDR_W-1:0] ADDR_BANK2 = 8'h29;
  localparam logic [ADDR_W-1:0] ADDR_READ  = 8'h2A;

  typedef struct packed {
    logic [3:0]  ref_sel;
    logic        xs;
    logic        cte;
    logic        dvs;
    logic        sns;
    logic [15:0] divisor;
  } bank1_t;

  typedef struct packed {
    logic [6:0] spare;
    logic [1:0] ul;
    logic [1:0] dz;
    logic [1:0] gate;
    logic [2:0] doc;
    logic [1:0] io_out;
    logic [3:0] bo;
    logic [1:0] io_dir;
  } bank2_t;

  localparam bank1_t BANK1_RST = '{ref_sel: 4'd0, xs: 1'b1, cte: 1'b0, dvs: 1'b0,
                                   sns: 1'b0, divisor: 16'd0};
  localparam bank2_t BANK2_RST = '0;

  typedef enum logic [2:0] {
    DOC_OPEN0  = 3'd0,
    DOC_UNLOCK = 3'd1,
    DOC_DONE   = 3'd2,
    DOC_PIN0   = 3'd5,
    DOC_PIN1   = 3'd6
  } doc_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [STAGES-1:0][N-1:0] stg_q;
  logic [N-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign q_o    = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import ctl_pkg::*;
#(
  parameter int STAT_W = 24,
  localparam int TOT_W = ADDR_W + FRAME_W,
  localparam int CNT_W = $clog2(TOT_W + 1) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic               ce_rise_i,
  input  logic               ce_fall_i,
  input  logic               sck_rise_i,
  input  logic               sck_fall_i,
  input  logic               sdi_i,
  input  logic [STAT_W-1:0]  status_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic               out_active_o,
  output logic               out_bit_o,
  output logic               wr1_o,
  output logic               wr2_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [FRAME_W-1:0] frame_q;
  logic [STAT_W-1:0]  out_sr_q;
  logic               out_act_q;
  logic [ADDR_W-1:0]  addr_nxt;

  assign addr_nxt = {sdi_i, addr_q[ADDR_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      addr_q    <= '0;
      frame_q   <= '0;
      out_sr_q  <= '0;
      out_act_q <= 1'b0;
    end else if (ce_rise_i) begin
      cnt_q     <= '0;
      out_act_q <= 1'b0;
    end else if (ce_fall_i) begin
      out_act_q <= 1'b0;
    end else if (ce_i && sck_rise_i) begin
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (cnt_q < CNT_W'(ADDR_W)) addr_q <= addr_nxt;
      else if (cnt_q < CNT_W'(TOT_W)) frame_q <= {sdi_i, frame_q[FRAME_W-1:1]};
      if (cnt_q == CNT_W'(ADDR_W - 1) && addr_nxt == ADDR_READ) begin
        out_act_q <= 1'b1;
        out_sr_q  <= status_i;
      end
    end else if (ce_i && sck_fall_i && out_act_q && cnt_q > CNT_W'(ADDR_W)) begin
      out_sr_q <= {out_sr_q[STAT_W-2:0], 1'b0};
    end
  end

  assign frame_o      = frame_q;
  assign addr_o       = addr_q;
  assign bit_cnt_o    = cnt_q;
  assign out_active_o = out_act_q;
  assign out_bit_o    = out_sr_q[STAT_W-1];
  assign wr1_o = ce_fall_i && cnt_q == CNT_W'(TOT_W) && addr_q == ADDR_BANK1;
  assign wr2_o = ce_fall_i && cnt_q == CNT_W'(TOT_W) && addr_q == ADDR_BANK2;
endmodule

// File: rtl/reg_banks.sv
module reg_banks
  import ctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr1_i,
  input  logic               wr2_i,
  input  logic [FRAME_W-1:0] frame_i,
  output bank1_t             bank1_o,
  output bank2_t             bank2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank1_o <= BANK1_RST;
      bank2_o <= BANK2_RST;
    end else begin
      if (wr1_i) bank1_o <= bank1_t'(frame_i);
      if (wr2_i) bank2_o <= bank2_t'(frame_i);
    end
  end
endmodule

// File: rtl/do_mux.sv
module do_mux
  import ctl_pkg::*;
(
  input  logic       ce_i,
  input  logic       out_active_i,
  input  logic       out_bit_i,
  input  logic [2:0] doc_i,
  input  logic       unlock_i,
  input  logic       done_i,
  input  logic [1:0] pin_i,
  input  logic [1:0] dir_i,
  output logic       do_low_o
);
  always_comb begin
    do_low_o = 1'b0;
    if (ce_i) begin
      if (out_active_i) do_low_o = ~out_bit_i;
    end else begin
      unique case (doc_i)
        DOC_UNLOCK: do_low_o = unlock_i;
        DOC_DONE:   do_low_o = done_i;
        DOC_PIN0:   do_low_o = ~dir_i[0] & ~pin_i[0];
        DOC_PIN1:   do_low_o = ~dir_i[1] & ~pin_i[1];
        default:    do_low_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/serial_ctl_if.sv
module serial_ctl_if
  import ctl_pkg::*;
#(
  parameter int STAT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [1:0]        io_pin_i,
  input  logic              unlock_i,
  input  logic              cnt_done_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [15:0]       divisor_o,
  output logic              sns_o,
  output logic              dvs_o,
  output logic              cte_o,
  output logic              xtal_sel_o,
  output logic [3:0]        ref_sel_o,
  output logic [1:0]        io_dir_o,
  output logic [3:0]        bo_low_o,
  output logic [1:0]        io_low_o,
  output logic [1:0]        gate_sel_o,
  output logic [1:0]        dz_sel_o,
  output logic [1:0]        ul_sel_o,
  output logic              do_low_o
);
  localparam int NSYNC = 5;
  localparam int CNT_W = $clog2(ADDR_W + FRAME_W + 1) + 1;

  logic [NSYNC-1:0] pin_q, pin_rise, pin_fall;
  logic             ce_s, ce_rise, ce_fall, sck_rise, sck_fall, sdi_s;
  logic [1:0]       io_pin_s;

  pin_sync #(.N(NSYNC), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({io_pin_i, sdi_i, sck_i, ce_i}),
    .q_o    (pin_q),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign ce_s     = pin_q[0];
  assign ce_rise  = pin_rise[0];
  assign ce_fall  = pin_fall[0];
  assign sck_rise = pin_rise[1];
  assign sck_fall = pin_fall[1];
  assign sdi_s    = pin_q[2];
  assign io_pin_s = pin_q[4:3];

  logic [FRAME_W-1:0] frame;
  logic [ADDR_W-1:0]  addr;
  logic [CNT_W-1:0]   bit_cnt;
  logic               out_active, out_bit, wr1, wr2;

  frame_rx #(.STAT_W(STAT_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ce_i         (ce_s),
    .ce_rise_i    (ce_rise),
    .ce_fall_i    (ce_fall),
    .sck_rise_i   (sck_rise),
    .sck_fall_i   (sck_fall),
    .sdi_i        (sdi_s),
    .status_i     (status_i),
    .frame_o      (frame),
    .addr_o       (addr),
    .bit_cnt_o    (bit_cnt),
    .out_active_o (out_active),
    .out_bit_o    (out_bit),
    .wr1_o        (wr1),
    .wr2_o        (wr2)
  );

  bank1_t bank1_q;
  bank2_t bank2_q;

  reg_banks u_banks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr1_i   (wr1),
    .wr2_i   (wr2),
    .frame_i (frame),
    .bank1_o (bank1_q),
    .bank2_o (bank2_q)
  );

  do_mux u_do (
    .ce_i         (ce_s),
    .out_active_i (out_active),
    .out_bit_i    (out_bit),
    .doc_i        (bank2_q.doc),
    .unlock_i     (unlock_i),
    .done_i       (cnt_done_i),
    .pin_i        (io_pin_s),
    .dir_i        (bank2_q.io_dir),
    .do_low_o     (do_low_o)
  );

  assign divisor_o  = bank1_q.divisor;
  assign sns_o      = bank1_q.sns;
  assign dvs_o      = bank1_q.dvs;
  assign cte_o      = bank1_q.cte;
  assign xtal_sel_o = bank1_q.xs;
  assign ref_sel_o  = bank1_q.ref_sel;
  assign io_dir_o   = bank2_q.io_dir;
  assign bo_low_o   = bank2_q.bo;
  assign io_low_o   = bank2_q.io_dir & bank2_q.io_out;
  assign gate_sel_o = bank2_q.gate;
  assign dz_sel_o   = bank2_q.dz;
  assign ul_sel_o   = bank2_q.ul;
endmodule

// File: rtl/serial_ctl_if_chk.sv
module serial_ctl_if_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_s,
  input logic             ce_fall,
  input logic             out_active,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [7:0]       addr,
  input logic [23:0]      bank1,
  input logic [23:0]      bank2,
  input logic             unlock_i,
  input logic [1:0]       io_dir_o,
  input logic [1:0]       io_low_o,
  input logic             do_low_o
);
  p_hold_until_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_fall |=> ($stable(bank1) && $stable(bank2)));

  p_bad_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_fall && bit_cnt != CNT_W'(32)) |=> ($stable(bank1) && $stable(bank2)));

  p_bad_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_fall && addr != 8'h28 && addr != 8'h29) |=> ($stable(bank1) && $stable(bank2)));

  p_open_in_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_s && !out_active) |-> !do_low_o);

  p_unlock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_s && bank2[10:8] == 3'd1) |-> (do_low_o == unlock_i));

  p_pin_out_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_s && ((bank2[10:8] == 3'd5 && io_dir_o[0]) || (bank2[10:8] == 3'd6 && io_dir_o[1])))
      |-> !do_low_o);

  p_io_drive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_low_o & ~io_dir_o) == 2'b00);
endmodule

bind serial_ctl_if serial_ctl_if_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_s       (ce_s),
  .ce_fall    (ce_fall),
  .out_active (out_active),
  .bit_cnt    (bit_cnt),
  .addr       (addr),
  .bank1      (bank1_q),
  .bank2      (bank2_q),
  .unlock_i   (unlock_i),
  .io_dir_o   (io_dir_o),
  .io_low_o   (io_low_o),
  .do_low_o   (do_low_o)
);

// File: tb/serial_ctl_if_tb.sv
module serial_ctl_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [1:0]  io_pin = 2'b11;
  logic        unlock = 1'b0, done = 1'b0;
  logic [23:0] status = '0;
  logic [15:0] divisor;
  logic        sns, dvs, cte, xs, do_low;
  logic [3:0]  ref_sel, bo_low;
  logic [1:0]  io_dir, io_low, gate, dz, ul;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [23:0] m1, m2;

  always #10 clk = ~clk;

  serial_ctl_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sck_i(sck), .sdi_i(sdi),
    .io_pin_i(io_pin), .unlock_i(unlock), .cnt_done_i(done), .status_i(status),
    .divisor_o(divisor), .sns_o(sns), .dvs_o(dvs), .cte_o(cte), .xtal_sel_o(xs),
    .ref_sel_o(ref_sel), .io_dir_o(io_dir), .bo_low_o(bo_low), .io_low_o(io_low),
    .gate_sel_o(gate), .dz_sel_o(dz), .ul_sel_o(ul), .do_low_o(do_low)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_do(input logic [2:0] doc, input logic ul_f, input logic dn,
                                  input logic [1:0] pin, input logic [1:0] dir);
    case (doc)
      3'd1: return ul_f;
      3'd2: return dn;
      3'd5: return !dir[0] && !pin[0];
      3'd6: return !dir[1] && !pin[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic send_bit(input logic b);
    sdi = b; wclk(3);
    sck = 1'b1; wclk(4);
    sck = 1'b0; wclk(3);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic ce_up;  ce = 1'b1; wclk(4); endtask
  task automatic ce_dn;  ce = 1'b0; wclk(6); endtask

  task automatic frame(input logic [7:0] a, input logic [31:0] d, input int n);
    ce_up; shift_bits({24'd0, a}, 8); shift_bits(d, n); ce_dn;
  endtask

  task automatic cmp_regs(input string tag);
    chk({tag, " R2 bank1"}, {8'd0, ref_sel, xs, cte, dvs, sns, divisor}, {8'd0, m1});
    chk({tag, " R3 bank2"}, {20'd0, ul, dz, gate, bo_low, io_dir},
        {20'd0, m2[16:11], m2[5:2], m2[1:0]});
    chk({tag, " R11 io_low"}, {30'd0, io_low}, {30'd0, m2[1:0] & m2[7:6]});
  endtask

  task automatic read_status(input string tag);
    ce_up; shift_bits({24'd0, 8'h2A}, 8);
    for (int k = 0; k < 24; k++) begin
      sdi = 1'b0; wclk(3);
      sck = 1'b1; wclk(4);
      chk({tag, " R10 read bit"}, {31'd0, do_low}, {31'd0, ~status[23-k]});
      sck = 1'b0; wclk(3);
    end
    ce_dn;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd1234));
    m1 = 24'h080000;  // crystal select set
    m2 = 24'h000000;
    wclk(3); rst_n = 1'b1; wclk(3);

    // R1 reset state
    chk("R1 bank1 reset", {8'd0, ref_sel, xs, cte, dvs, sns, divisor}, 32'h00080000);
    chk("R1 bank2 reset", {20'd0, ul, dz, gate, bo_low, io_dir}, 32'd0);
    chk("R1 io_low reset", {30'd0, io_low}, 32'd0);
    chk("R1 do open", {31'd0, do_low}, 32'd0);

    // R2 / R3 directed
    frame(8'h28, 32'h00A5_1234, 24); m1 = 24'hA51234; cmp_regs("dir1");
    frame(8'h29, 32'h0001_FFFF, 24); m2 = 24'h01FFFF; cmp_regs("dir2");

    // R4: values held while CE high
    ce_up; shift_bits({24'd0, 8'h28}, 8); shift_bits(32'h0012_3456, 24);
    wclk(6);
    chk("R4 held before fall", {16'd0, divisor}, {16'd0, m1[15:0]});
    ce_dn; m1 = 24'h123456;
    chk("R4 updated after fall", {16'd0, divisor}, 32'h3456);

    // R5 unknown address
    frame(8'h2B, 32'h00FF_FFFF, 24); cmp_regs("R5 addr2B");
    frame(8'h14, 32'h0000_0000, 24); cmp_regs("R5 addr14");

    // R6 wrong length
    frame(8'h28, 32'h0000_0000, 23); cmp_regs("R6 short");
    frame(8'h29, 32'h0000_0000, 25); cmp_regs("R6 long");

    // R8 sources: code 1 (unlock), 2 (done), others open
    frame(8'h29, 32'h0000_0100, 24); m2 = 24'h000100;
    unlock = 1'b1; wclk(2); chk("R8 unlock low", {31'd0, do_low}, 32'd1);
    unlock = 1'b0; wclk(2); chk("R8 unlock open", {31'd0, do_low}, 32'd0);

    // R7: open during input transfer while unlock asserted
    unlock = 1'b1;
    ce_up; shift_bits({24'd0, 8'h29}, 8); shift_bits(32'h0000_0200, 12);
    chk("R7 open in transfer", {31'd0, do_low}, 32'd0);
    shift_bits(32'h0000_0000, 12); ce_dn; m2 = 24'h000200;
    unlock = 1'b1; done = 1'b1; wclk(2);
    chk("R8 done low", {31'd0, do_low}, 32'd1);
    done = 1'b0; wclk(2);
    chk("R8 done open", {31'd0, do_low}, 32'd0);
    foreach (m2[i]) ;  // no-op
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c == 3 || c == 4 || c == 7) begin
        frame(8'h29, {21'd0, 3'(c), 8'h00}, 24); m2 = {13'd0, 3'(c), 8'h00};
        unlock = 1'b1; done = 1'b1; io_pin = 2'b00; wclk(4);
        chk("R8 other code open", {31'd0, do_low}, 32'd0);
      end
    end
    unlock = 1'b0; done = 1'b0;

    // R9 pin routing
    frame(8'h29, 32'h0000_0500, 24); m2 = 24'h000500;
    io_pin = 2'b10; wclk(5); chk("R9 pin0 low", {31'd0, do_low}, 32'd1);
    io_pin = 2'b11; wclk(5); chk("R9 pin0 high", {31'd0, do_low}, 32'd0);
    frame(8'h29, 32'h0000_0600, 24); m2 = 24'h000600;
    io_pin = 2'b01; wclk(5); chk("R9 pin1 low", {31'd0, do_low}, 32'd1);
    frame(8'h29, 32'h0000_0602, 24); m2 = 24'h000602;
    wclk(5); chk("R9 pin1 output open", {31'd0, do_low}, 32'd0);
    frame(8'h29, 32'h0000_05C1, 24); m2 = 24'h0005C1;
    io_pin = 2'b00; wclk(5); chk("R9 pin0 output open", {31'd0, do_low}, 32'd0);
    cmp_regs("R11 dir1 out");

    // R10 directed read
    status = 24'hC3_5A0F; read_status("dir"); cmp_regs("R10 no write");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int kind;
      kind = int'($urandom % 5);
      d = $urandom;
      io_pin = 2'($urandom); unlock = 1'($urandom); done = 1'($urandom);
      case (kind)
        0: begin frame(8'h28, d, 24); m1 = d[23:0]; end
        1: begin frame(8'h29, d, 24); m2 = d[23:0]; end
        2: begin
          logic [7:0] a;
          a = 8'($urandom);
          if (a == 8'h28 || a == 8'h29 || a == 8'h2A) a = 8'h00;
          frame(a, d, 24);
        end
        3: frame(($urandom % 2) ? 8'h28 : 8'h29, d, (($urandom % 2) ? 24 + 1 + int'($urandom % 3)
                                                               : 24 - 1 - int'($urandom % 3)));
        default: begin status = 24'($urandom); read_status("rnd"); end
      endcase
      cmp_regs("rnd");
      wclk(2);
      chk("R8 R9 rnd idle do", {31'd0, do_low},
          {31'd0, exp_do(m2[10:8], unlock, done, io_pin, m2[1:0])});
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule